// File: doc/BRIEF.md
# Fractional Carrier Offset Estimator

This block measures the fractional part of the carrier frequency offset of an OFDM receiver while it is acquiring a signal. The cyclic prefix repeats the last samples of each symbol, so each received sample is multiplied by the complex conjugate of the sample one FFT length earlier. A 2^`DLY_AW`-deep sample memory supplies that earlier sample. Only the part of the guard interval that is free of inter-symbol interference is summed. A programmable number of leading guard samples is left out of the sum.

At the end of the window, the phase of the complex sum is turned into an offset in fractions of a subcarrier spacing. The arctangent unit adds no divider and no constant multiplier. It takes base-2 logarithms of both magnitudes through a small table and subtracts them. It then looks up an angle for the difference, with the 1/(2π) scaling already in that table, and resolves the octant from the signs and from which magnitude is larger. One estimate comes out per symbol, as a registered value with a one-cycle strobe.

The timing, mode and guard detectors upstream provide the symbol-start marker, the FFT length and the guard length. The defaults support 2k mode (FFT length 2048) with a 1/32 guard (64 samples).

Top module: `cfo_frac_est`

## Requirements
- R1: The block accumulates the correlation x[n]·conj(x[n−N]), where N is `fft_len`: the real part is xi[n]·xi[n−N] + xq[n]·xq[n−N] and the imaginary part is xq[n]·xi[n−N] − xi[n]·xq[n−N].
- R2: Sample indices count accepted samples, with index 0 being the sample that carries `sym_start`. Only indices N+`skip_len` through N+`guard_len`−1 enter the sum, so the first `skip_len` guard samples have no effect on the estimate.
- R3: `eps` is a two's-complement code of `OW` bits, where code c means c/2^OW subcarrier spacings. This covers [−0.5, 0.5), and +0.5 wraps to −2^(OW−1). With the default `OW`=12, the code is within ±24 LSB of atan2(Im, Re)/(2π)·2^OW of the accumulated sum.
- R4: `eps_valid` is a one-cycle pulse at the first clock edge after the edge that accepts window index N+`guard_len`−1. `eps` holds its value between pulses.
- R5: At most one estimate is produced for each `sym_start` marker. Samples after the window and before the next marker produce no pulse.
- R6: A marker clears the running sum, so an estimate depends only on samples since the latest marker, even when a previous symbol was cut off inside its window.
- R7: A zero sum gives `eps` = 0 exactly. This happens with all-zero input, or when `skip_len` ≥ `guard_len` and the window is empty.
- R8: Cycles with `in_valid` low are ignored entirely. The sample, the marker, the memory and the index counter are all left untouched.
- R9: During and after a synchronous active-low reset, `eps` is 0 and `eps_valid` is low. No estimate is produced until a marker is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| sym_start | input | 1 | First sample of a symbol (with in_valid) |
| in_i | input | SW | Sample, in-phase (signed) |
| in_q | input | SW | Sample, quadrature (signed) |
| fft_len | input | DLY_AW+1 | FFT length N, 2..2^DLY_AW |
| guard_len | input | GW | Guard interval length in samples |
| skip_len | input | GW | Leading guard samples to discard |
| eps | output | OW | Fractional offset estimate (signed) |
| eps_valid | output | 1 | One-cycle estimate strobe |

## Verification
The bench builds the block with a 64-entry sample memory, 5-bit guard and skip fields, 8-bit samples and a 12-bit output. With these values, an FFT length equal to the full memory depth can be reached, as well as non-power-of-two lengths, guards up to 16 and stall gaps, all in a few hundred cycles. The leading guard samples are deliberately corrupted, so using them would visibly move the estimate. Offsets near ±0.5 exercise the wrap of the output code. Separate cases cover restarts in the middle of a window, empty windows and unmarked sample streams.

// File: rtl/cfo_frac_pkg.sv
// Shared constants and table generators for the fractional offset estimator.
// Assumes elaboration-time real arithmetic for table construction only.
package cfo_frac_pkg;
    localparam int  MANT_W  = 6;                 // mantissa bits into the log table
    localparam int  MANT_N  = 1 << MANT_W;
    localparam int  LOG_FW  = 8;                 // fractional bits of a log2 value
    localparam int  DIDX_FW = 4;                 // fractional bits of the difference index
    localparam int  DIDX_IW = 3;                 // integer bits of the difference index
    localparam int  DIDX_W  = DIDX_FW + DIDX_IW;
    localparam int  DIDX_N  = 1 << DIDX_W;
    localparam real TWO_PI  = 6.283185307179586;

    // Fractional part of log2(1.m), evaluated at the centre of each mantissa bin.
    function automatic int log_frac_entry(input int m);
        real x;
        x = 1.0 + (real'(m) + 0.5) / real'(MANT_N);
        return $rtoi($ln(x) / $ln(2.0) * real'(1 << LOG_FW) + 0.5);
    endfunction

    // Angle in turns scaled by 2^ow for a log2 ratio at the centre of bin k.
    function automatic int atan_entry(input int k, input int ow);
        real d;
        real a;
        d = (real'(k) + 0.5) / real'(1 << DIDX_FW);
        a = $atan(2.0 ** (-d)) / TWO_PI * real'(1 << ow);
        return $rtoi(a + 0.5);
    endfunction
endpackage

// File: rtl/cfo_delay_line.sv
// Sample memory giving the sample written LAG accepted samples earlier.
// Assumes lag <= 2^AW; a lag equal to the depth reads the slot being overwritten
// (read happens before the write at the edge). Contents are not reset.
module cfo_delay_line #(
    parameter int DW = 16,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW:0]   lag,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          unused_lag_msb;

    assign unused_lag_msb = lag[AW];
    assign rd_ptr  = wr_ptr - lag[AW-1:0];
    assign rd_data = mem[rd_ptr];

    // Advance the write pointer on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
    end

    // Store each accepted sample.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end
endmodule

// File: rtl/cfo_corr_acc.sv
// Index counter and complex correlation accumulator over the usable guard window.
// Window: indices fft_len+skip_len .. fft_len+guard_len-1 after the marker sample.
// Assumes guard field width GW <= AW and fft_len >= 2. The counter saturates, so
// after the window (or after reset) no further end strobe occurs until a marker.
module cfo_corr_acc #(
    parameter int SW   = 8,
    parameter int AW   = 11,
    parameter int GW   = 10,
    parameter int ACCW = 27
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   sym_start,
    input  logic signed [SW-1:0]   cur_i,
    input  logic signed [SW-1:0]   cur_q,
    input  logic signed [SW-1:0]   old_i,
    input  logic signed [SW-1:0]   old_q,
    input  logic [AW:0]            fft_len,
    input  logic [GW-1:0]          guard_len,
    input  logic [GW-1:0]          skip_len,
    output logic signed [ACCW-1:0] sum_i,
    output logic signed [ACCW-1:0] sum_q,
    output logic                   done
);
    localparam int           CW      = AW + 2;
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt, cur_idx, win_lo, win_end;
    logic          in_win, is_last, new_sym;
    logic signed [2*SW-1:0] m_ii, m_qq, m_qi, m_iq;
    logic signed [ACCW-1:0] p_re, p_im, acc_i, acc_q, nxt_i, nxt_q;

    assign new_sym = in_valid && sym_start;
    assign cur_idx = new_sym ? '0 : cnt;
    assign win_lo  = CW'(fft_len) + CW'(skip_len);
    assign win_end = CW'(fft_len) + CW'(guard_len);
    assign in_win  = in_valid && (cur_idx >= win_lo) && (cur_idx < win_end);
    assign is_last = in_valid && ((cur_idx + CW'(1)) == win_end);

    // Product of the current sample with the conjugate of the delayed one.
    always_comb begin
        m_ii = cur_i * old_i;
        m_qq = cur_q * old_q;
        m_qi = cur_q * old_i;
        m_iq = cur_i * old_q;
        p_re = ACCW'(m_ii) + ACCW'(m_qq);
        p_im = ACCW'(m_qi) - ACCW'(m_iq);
        nxt_i = (new_sym ? '0 : acc_i) + (in_win ? p_re : '0);
        nxt_q = (new_sym ? '0 : acc_q) + (in_win ? p_im : '0);
    end

    // Sample index since the last marker, saturating at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= CNT_MAX;
        else if (in_valid) cnt <= (cur_idx == CNT_MAX) ? CNT_MAX : cur_idx + CW'(1);
    end

    // Running complex sum, restarted by each marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_i <= '0;
            acc_q <= '0;
        end else if (in_valid) begin
            acc_i <= nxt_i;
            acc_q <= nxt_q;
        end
    end

    // Capture the final sum and strobe once at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_i <= '0;
            sum_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= is_last;
            if (is_last) begin
                sum_i <= nxt_i;
                sum_q <= nxt_q;
            end
        end
    end
endmodule

// File: rtl/cfo_log2_unit.sv
// Combinational base-2 logarithm: leading-one position plus a table of the
// fractional part indexed by the next MANT_W bits. Output for zero is undefined
// and must be masked by the user. Assumes IW > MANT_W.
module cfo_log2_unit #(
    parameter int IW = 27,
    parameter int PW = $clog2(IW),
    parameter int LW = PW + cfo_frac_pkg::LOG_FW
) (
    input  logic [IW-1:0] mag,
    output logic [LW-1:0] log_val
);
    import cfo_frac_pkg::*;

    logic [LOG_FW-1:0] frac_lut [MANT_N];
    logic [PW-1:0]     pos;
    logic [IW-1:0]     norm;
    logic [MANT_W-1:0] mant;
    logic              unused_norm;

    for (genvar g = 0; g < MANT_N; g++) begin : g_frac
        localparam int VAL = log_frac_entry(g);
        assign frac_lut[g] = LOG_FW'(VAL);
    end

    // Leading-one search, then normalise so the leading one sits at the top.
    always_comb begin
        pos = '0;
        for (int b = 0; b < IW; b++) begin
            if (mag[b]) pos = PW'(b);
        end
        norm    = mag << (PW'(IW - 1) - pos);
        mant    = norm[IW-2 -: MANT_W];
        log_val = {pos, frac_lut[mant]};
    end

    assign unused_norm = ^{norm[IW-1], norm[IW-MANT_W-2:0]};
endmodule

// File: rtl/cfo_log_atan.sv
// Division-free arctangent in turns: log-domain magnitude ratio, one angle table
// with the 1/(2*pi) scale folded in, octant folding by swap and signs.
// Registers the code and a one-cycle valid one clock after go.
module cfo_log_atan #(
    parameter int IW = 27,
    parameter int OW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic signed [IW-1:0] re,
    input  logic signed [IW-1:0] im,
    output logic signed [OW-1:0] eps,
    output logic                 eps_valid
);
    import cfo_frac_pkg::*;

    localparam int          PW      = $clog2(IW);
    localparam int          LW      = PW + LOG_FW;
    localparam int          IDX_LO  = LOG_FW - DIDX_FW;
    localparam int          SAT_LO  = LOG_FW + DIDX_IW;
    localparam logic [OW-1:0] QUARTER = OW'(1) << (OW - 2);
    localparam logic [OW-1:0] HALF    = OW'(1) << (OW - 1);

    logic [IW-1:0]       mag_re, mag_im;
    logic [IW-1:0]       mags [2];
    logic [LW-1:0]       logs [2];
    logic                swap;
    logic signed [LW:0]  diff;
    logic [DIDX_W-1:0]   idx;
    logic [OW-1:0]       atan_lut [DIDX_N];
    logic [OW-1:0]       oct_ang, r1, r2, r3;
    logic                unused_diff_lo;

    for (genvar g = 0; g < DIDX_N; g++) begin : g_atan
        localparam int VAL = atan_entry(g, OW);
        assign atan_lut[g] = OW'(VAL);
    end

    assign mag_re  = re[IW-1] ? IW'(-re) : IW'(re);
    assign mag_im  = im[IW-1] ? IW'(-im) : IW'(im);
    assign swap    = mag_im > mag_re;
    assign mags[0] = swap ? mag_im : mag_re;
    assign mags[1] = swap ? mag_re : mag_im;

    for (genvar g = 0; g < 2; g++) begin : g_log
        cfo_log2_unit #(.IW(IW), .PW(PW), .LW(LW)) u_log (
            .mag     (mags[g]),
            .log_val (logs[g])
        );
    end

    assign diff = $signed({1'b0, logs[0]}) - $signed({1'b0, logs[1]});
    assign idx  = diff[SAT_LO-1:IDX_LO];
    assign unused_diff_lo = ^diff[IDX_LO-1:0];

    // First-octant angle, then fold into the full circle.
    always_comb begin
        if (mags[1] == '0 || (!diff[LW] && diff[LW-1:SAT_LO] != '0)) oct_ang = '0;
        else if (diff[LW])                                            oct_ang = atan_lut[0];
        else                                                          oct_ang = atan_lut[idx];
        r1 = swap ? QUARTER - oct_ang : oct_ang;
        r2 = re[IW-1] ? HALF - r1 : r1;
        r3 = im[IW-1] ? OW'(-r2) : r2;
    end

    // Register the estimate and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eps       <= '0;
            eps_valid <= 1'b0;
        end else begin
            eps_valid <= go;
            if (go) eps <= $signed(r3);
        end
    end
endmodule

// File: rtl/cfo_frac_est.sv
// Fractional carrier offset estimator: delayed-conjugate correlation over the
// trimmed guard window, then log-domain arctangent to subcarrier fractions.
// Assumes GW <= DLY_AW, 2 <= fft_len <= 2^DLY_AW and sym_start qualified by in_valid.
module cfo_frac_est #(
    parameter int SW     = 8,
    parameter int DLY_AW = 11,
    parameter int GW     = 10,
    parameter int OW     = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 sym_start,
    input  logic signed [SW-1:0] in_i,
    input  logic signed [SW-1:0] in_q,
    input  logic [DLY_AW:0]      fft_len,
    input  logic [GW-1:0]        guard_len,
    input  logic [GW-1:0]        skip_len,
    output logic signed [OW-1:0] eps,
    output logic                 eps_valid
);
    localparam int ACCW = 2 * SW + 1 + GW;

    logic [2*SW-1:0]        dly_out;
    logic signed [ACCW-1:0] sum_i, sum_q;
    logic                   acc_done;

    cfo_delay_line #(.DW(2 * SW), .AW(DLY_AW)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_data ({in_i, in_q}),
        .lag     (fft_len),
        .rd_data (dly_out)
    );

    cfo_corr_acc #(.SW(SW), .AW(DLY_AW), .GW(GW), .ACCW(ACCW)) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sym_start (sym_start),
        .cur_i     (in_i),
        .cur_q     (in_q),
        .old_i     ($signed(dly_out[2*SW-1:SW])),
        .old_q     ($signed(dly_out[SW-1:0])),
        .fft_len   (fft_len),
        .guard_len (guard_len),
        .skip_len  (skip_len),
        .sum_i     (sum_i),
        .sum_q     (sum_q),
        .done      (acc_done)
    );

    cfo_log_atan #(.IW(ACCW), .OW(OW)) u_atan (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (acc_done),
        .re        (sum_i),
        .im        (sum_q),
        .eps       (eps),
        .eps_valid (eps_valid)
    );
endmodule

// File: rtl/cfo_frac_est_chk.sv
// Property checker for cfo_frac_est, attached by bind below.
module cfo_frac_est_chk #(
    parameter int ACCW = 27,
    parameter int OW   = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 sym_start,
    input logic                 acc_done,
    input logic signed [ACCW-1:0] sum_i,
    input logic signed [ACCW-1:0] sum_q,
    input logic signed [OW-1:0] eps,
    input logic                 eps_valid
);
    logic armed;

    // Tracks a marker that has not yet produced its end-of-window strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                     armed <= 1'b0;
        else if (in_valid && sym_start) armed <= 1'b1;
        else if (acc_done)              armed <= 1'b0;
    end

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eps_valid |=> !eps_valid);
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> eps_valid);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !eps_valid |-> $stable(eps));
    assert_one_per_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> $past(armed));
    assert_zero_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && sum_i == '0 && sum_q == '0) |=> (eps == '0));
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!eps_valid && eps == '0));
endmodule

bind cfo_frac_est cfo_frac_est_chk #(.ACCW(ACCW), .OW(OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sym_start (sym_start),
    .acc_done  (acc_done),
    .sum_i     (sum_i),
    .sum_q     (sum_q),
    .eps       (eps),
    .eps_valid (eps_valid)
);

// File: tb/sim_cfo_frac_est.sv
// Self-checking bench: vector table walked by one loop, then directed cases.
module sim_cfo_frac_est;
    localparam int  SW = 8, DAW = 6, GW = 5, OW = 12, TOL = 24, NV = 8;
    localparam real TWO_PI = 6.283185307179586;

    typedef struct packed { int n; int g; int d; int eps_m; int gap; } vec_t;
    localparam vec_t VEC [NV] = '{
        '{32,  8, 0,  100, 0}, '{32,  8, 2, -300, 0}, '{32,  8, 6,  450, 1},
        '{64, 16, 4, -490, 0}, '{64, 16, 0,    0, 2}, '{16,  4, 0,  200, 0},
        '{64,  2, 0,  333, 1}, '{48, 12, 3, -125, 0}
    };

    logic                 clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sym_start = 1'b0;
    logic signed [SW-1:0] in_i = '0, in_q = '0;
    logic [DAW:0]         fft_len = 32;
    logic [GW-1:0]        guard_len = 8, skip_len = 0;
    logic signed [OW-1:0] eps;
    logic                 eps_valid;

    int     checks = 0, fails = 0, pulses = 0, got_eps = 0, got_cyc = 0, acc_cyc = 0, cyc = 0;
    longint exp_si = 0, exp_sq = 0;

    cfo_frac_est #(.SW(SW), .DLY_AW(DAW), .GW(GW), .OW(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_start(sym_start),
        .in_i(in_i), .in_q(in_q), .fft_len(fft_len), .guard_len(guard_len),
        .skip_len(skip_len), .eps(eps), .eps_valid(eps_valid)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && eps_valid) begin
        pulses++;
        got_eps = int'(eps);
        got_cyc = cyc;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic int rnd(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic int clip(input int x);
        return (x > 127) ? 127 : ((x < -127) ? -127 : x);
    endfunction

    function automatic int rand_amp(input int amp);
        return int'($urandom_range(2 * amp)) - amp;
    endfunction

    function automatic int exp_code();
        real a;
        if (exp_si == 0 && exp_sq == 0) return 0;
        a = $atan2(real'(exp_sq), real'(exp_si)) / TWO_PI * real'(1 << OW);
        return rnd(a);
    endfunction

    function automatic int wrap_diff(input int a, input int b);
        int d;
        d = (a - b) % (1 << OW);
        d = (d + (1 << OW) + (1 << (OW - 1))) % (1 << OW);
        return d - (1 << (OW - 1));
    endfunction

    task automatic put(input int i, input int q, input bit ss);
        in_valid = 1'b1; in_i = SW'(i); in_q = SW'(q); sym_start = ss;
        @(negedge clk);
    endtask

    // Stall cycles; noisy stalls carry a marker and garbage data that must be ignored.
    task automatic idle(input int k, input bit noisy);
        repeat (k) begin
            in_valid = 1'b0; sym_start = noisy;
            in_i = noisy ? SW'(rand_amp(120)) : '0;
            in_q = noisy ? SW'(rand_amp(120)) : '0;
            @(negedge clk);
        end
        sym_start = 1'b0;
    endtask

    // Builds one rotated symbol with cyclic prefix, corrupts the first d guard
    // samples, computes the expected window sum and drives it.
    task automatic run_symbol(input int n, input int g, input int d, input int eps_m,
                              input int gap, input int amp, input int extra, input int stop_at);
        int ui [64]; int uq [64]; int ri [128]; int rq [128];
        int last;
        real ang;
        for (int k = 0; k < n; k++) begin
            ui[k] = rand_amp(amp); uq[k] = rand_amp(amp);
        end
        for (int t = 0; t < n + g; t++) begin
            int src;
            src = (t < g) ? (n - g + t) : (t - g);
            ang = TWO_PI * real'(eps_m) / 1000.0 * real'(t) / real'(n);
            ri[t] = clip(rnd(real'(ui[src]) * $cos(ang) - real'(uq[src]) * $sin(ang)));
            rq[t] = clip(rnd(real'(ui[src]) * $sin(ang) + real'(uq[src]) * $cos(ang)));
            if (t < d && amp > 0) begin
                ri[t] = rand_amp(120); rq[t] = rand_amp(120);
            end
        end
        exp_si = 0; exp_sq = 0;
        for (int t = n + d; t < n + g; t++) begin
            exp_si += longint'(ri[t] * ri[t-n] + rq[t] * rq[t-n]);
            exp_sq += longint'(rq[t] * ri[t-n] - ri[t] * rq[t-n]);
        end
        fft_len = (DAW+1)'(n); guard_len = GW'(g); skip_len = GW'(d);
        pulses = 0;
        last = (stop_at < 0) ? n + g : stop_at;
        for (int t = 0; t < last; t++) begin
            put(ri[t], rq[t], t == 0);
            if (t == n + g - 1) acc_cyc = cyc;
            if (gap > 0) idle(gap, 1'b1);
        end
        for (int e = 0; e < extra; e++) put(rand_amp(amp), rand_amp(amp), 1'b0);
        idle(4, 1'b0);
    endtask

    // Value, latency, count and hold checks after a complete symbol.
    task automatic check_result(input string vreq);
        int e;
        e = exp_code();
        chk(wrap_diff(got_eps, e) <= TOL && wrap_diff(got_eps, e) >= -TOL, vreq, "estimate", got_eps, e);
        chk(got_cyc - acc_cyc == 1, "R4", "strobe latency", got_cyc - acc_cyc, 1);
        chk(pulses == 1, "R5", "strobes per symbol", pulses, 1);
        chk(int'(eps) == got_eps, "R4", "hold between strobes", int'(eps), got_eps);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R9: quiet outputs while reset is held.
        chk(eps_valid == 1'b0, "R9", "valid in reset", int'(eps_valid), 0);
        chk(eps == '0, "R9", "estimate in reset", int'(eps), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: unmarked samples after reset produce no estimate.
        pulses = 0;
        for (int k = 0; k < 70; k++) put(rand_amp(80), rand_amp(80), 1'b0);
        idle(4, 1'b0);
        chk(pulses == 0, "R9", "strobes without marker", pulses, 0);
        chk(eps == '0, "R9", "estimate without marker", int'(eps), 0);

        // Table: R1 R2 R3 (R8 when the vector has stall gaps).
        for (int v = 0; v < NV; v++) begin
            run_symbol(VEC[v].n, VEC[v].g, VEC[v].d, VEC[v].eps_m, VEC[v].gap, 80, 20, -1);
            check_result(VEC[v].gap > 0 ? "R1 R2 R3 R8" : "R1 R2 R3");
        end

        // R7: all-zero samples give exactly zero.
        run_symbol(32, 8, 0, 0, 0, 0, 0, -1);
        chk(got_eps == 0 && pulses == 1, "R7", "zero input", got_eps, 0);

        // R7 / R2: discard covers the whole guard, empty window.
        run_symbol(32, 4, 4, 250, 0, 80, 0, -1);
        chk(got_eps == 0 && pulses == 1, "R7", "empty window", got_eps, 0);
        run_symbol(32, 4, 9, -250, 0, 80, 0, -1);
        chk(got_eps == 0 && pulses == 1, "R7", "discard beyond guard", got_eps, 0);

        // R6: symbol cut off inside its window, then a fresh marker.
        run_symbol(32, 8, 1, 400, 0, 80, 0, 36);
        chk(pulses == 0, "R6", "strobes from cut symbol", pulses, 0);
        run_symbol(32, 8, 1, -200, 0, 80, 0, -1);
        check_result("R6");

        // R5: a long unmarked tail after the window adds nothing.
        run_symbol(16, 4, 1, 150, 0, 80, 60, -1);
        check_result("R5 R3");

        // R3: offset at the positive edge wraps to the negative end.
        run_symbol(32, 8, 0, 499, 0, 80, 0, -1);
        check_result("R3");

        summary();
        $finish;
    end
endmodule